// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Core

This block is a small processor core built around one 16-bit accumulator. It holds a program counter and an instruction register next to that accumulator. It runs each instruction as two stages, a fetch stage and then an execute stage. Instruction words and data words are both 16 bits. The upper four bits of an instruction select the operation. The lower twelve bits give either a word address in memory or the number of an I/O device.

The core reaches memory through a synchronous port with one cycle of read latency. The address is presented in one cycle and the read word arrives in the next. I/O uses a request/acknowledge handshake, and the core waits in its execute stage until the device answers. Data is held in sign-magnitude form: bit 15 is the sign and bits 14..0 are the magnitude. The add follows sign-magnitude rules and keeps a sticky overflow flag. An opcode outside the defined set stops the core for good.

The memory and the devices sit outside the block. The parent design wires them to the two ports, loads a program at the start address and releases reset.

Top module: `acc_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the outputs read as follows. The program counter equals the RESET_PC parameter (default 0x300). The instruction register and the accumulator read 0000. The overflow flag, halted, mem_we and io_req are all low.
- R2: The fetch stage lasts two cycles. In its first cycle mem_addr carries the program counter. At the end of its second cycle the returned word is in the instruction register and the program counter has risen by one.
- R3: Opcode 0x1 (instruction bits 15..12) loads the accumulator from the memory word addressed by bits 11..0. Its execute stage lasts two cycles.
- R4: Opcode 0x2 writes the accumulator to the memory word addressed by bits 11..0. The execute stage is one cycle, in which mem_we is high for exactly that cycle with mem_addr equal to the operand.
- R5: Opcode 0x5 adds the addressed memory word to the accumulator. The execute stage lasts two cycles. When the signs are equal, the magnitudes add and the sign is kept.
- R6: When the signs in an add differ, the result is the larger magnitude minus the smaller, with the sign of the larger. A zero result is always written as 0000, positive zero, and this holds for a sum of two negative zeros too.
- R7: A carry out of bit 14 of the magnitude in an add sets the overflow flag and leaves the wrapped magnitude in the accumulator. Once set, the flag stays set until reset.
- R8: Opcode 0x3 raises io_req with io_dir low and io_dev set to bits 11..0. The core holds the request steady and leaves the accumulator unchanged until it samples io_ack high. In that cycle it loads io_rdata into the accumulator.
- R9: Opcode 0x7 raises io_req with io_dir high and io_wdata equal to the accumulator. It holds the request until io_ack, and the accumulator is left unchanged.
- R10: Any opcode other than 0x1, 0x2, 0x3, 0x5 or 0x7 raises halted at the end of its execute cycle. From then on, halted stays high, the program counter stays put, and there are no more memory writes or I/O requests.
- R11: Load from a word holding 3, add a word holding 2, then store back to that second word. The second word ends up holding 0005 and the program counter stands one past the third instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after its address |
| io_req | output | 1 | I/O transfer request |
| io_dir | output | 1 | 1 = write to device, 0 = read from device |
| io_dev | output | 12 | Device number |
| io_wdata | output | 16 | Data to device |
| io_rdata | input | 16 | Data from device |
| io_ack | input | 1 | Device acknowledge |
| pc | output | 12 | Program counter |
| ir | output | 16 | Instruction register |
| ac | output | 16 | Accumulator |
| ovf | output | 1 | Sticky add overflow |
| halted | output | 1 | Core stopped on an undefined opcode |

## Verification
The bench builds the core with the default start address of 0x300. With that value, the three-instruction example (load, add, store back) runs at its natural addresses, and the bench checks every stage cycle by cycle. The device model stretches its acknowledge over several cycles to expose the wait in execute. The add cases reach both sign orders, cancellation to zero, a sum of two negative zeros and a magnitude carry.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int OPND_W = WORD_W - OPC_W;
    localparam int MAG_W  = WORD_W - 1;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
    localparam logic [OPC_W-1:0] OPC_IN    = 4'h3;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_OUT   = 4'h7;

    typedef enum logic [2:0] {
        K_LOAD, K_STORE, K_ADD, K_IN, K_OUT, K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [OPND_W-1:0]   operand;
    } dec_t;

    typedef enum logic [2:0] {
        ST_FADDR, ST_FDATA, ST_XADDR, ST_XDATA, ST_HALT
    } stage_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              ovf;
    } smsum_t;

    function automatic logic sm_sign(input logic [WORD_W-1:0] w);
        return w[WORD_W-1];
    endfunction

    function automatic logic [MAG_W-1:0] sm_mag(input logic [WORD_W-1:0] w);
        return w[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_t              dec
);
    logic [OPC_W-1:0] opc;

    assign opc = instr[WORD_W-1:OPND_W];

    always_comb begin
        dec.operand = instr[OPND_W-1:0];
        case (opc)
            OPC_LOAD:  dec.kind = K_LOAD;
            OPC_STORE: dec.kind = K_STORE;
            OPC_IN:    dec.kind = K_IN;
            OPC_ADD:   dec.kind = K_ADD;
            OPC_OUT:   dec.kind = K_OUT;
            default:   dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/acc_smadd.sv
module acc_smadd
    import acc_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output smsum_t            res
);
    logic              sa, sb, sign, a_ge_b;
    logic [MAG_W-1:0]  ma, mb, mag;
    logic [MAG_W:0]    wide;

    assign sa = sm_sign(a);
    assign sb = sm_sign(b);
    assign ma = sm_mag(a);
    assign mb = sm_mag(b);
    assign a_ge_b = (ma >= mb);

    always_comb begin
        wide    = {1'b0, ma} + {1'b0, mb};
        res.ovf = 1'b0;
        if (sa == sb) begin
            mag     = wide[MAG_W-1:0];
            res.ovf = wide[MAG_W];
            sign    = sa;
        end else if (a_ge_b) begin
            mag  = ma - mb;
            sign = sa;
        end else begin
            mag  = mb - ma;
            sign = sb;
        end
        if (mag == '0) sign = 1'b0;
        res.word = {sign, mag};
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter logic [OPND_W-1:0] RESET_PC = 12'h300
) (
    input  logic              clk,
    input  logic              rst,
    output logic [OPND_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              io_req,
    output logic              io_dir,
    output logic [OPND_W-1:0] io_dev,
    output logic [WORD_W-1:0] io_wdata,
    input  logic [WORD_W-1:0] io_rdata,
    input  logic              io_ack,
    output logic [OPND_W-1:0] pc,
    output logic [WORD_W-1:0] ir,
    output logic [WORD_W-1:0] ac,
    output logic              ovf,
    output logic              halted
);
    stage_e            stage_q;
    logic [OPND_W-1:0] pc_q;
    logic [WORD_W-1:0] ir_q, ac_q;
    logic              ovf_q;
    dec_t              dec;
    smsum_t            sum;
    logic              in_exec;

    acc_decode u_dec (.instr(ir_q), .dec(dec));
    acc_smadd  u_add (.a(ac_q), .b(mem_rdata), .res(sum));

    assign in_exec   = (stage_q == ST_XADDR);
    assign mem_addr  = in_exec ? dec.operand : pc_q;
    assign mem_we    = in_exec && (dec.kind == K_STORE);
    assign mem_wdata = ac_q;
    assign io_req    = in_exec && (dec.kind == K_IN || dec.kind == K_OUT);
    assign io_dir    = (dec.kind == K_OUT);
    assign io_dev    = dec.operand;
    assign io_wdata  = ac_q;
    assign pc        = pc_q;
    assign ir        = ir_q;
    assign ac        = ac_q;
    assign ovf       = ovf_q;
    assign halted    = (stage_q == ST_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_FADDR;
            pc_q    <= RESET_PC;
            ir_q    <= '0;
            ac_q    <= '0;
            ovf_q   <= 1'b0;
        end else begin
            case (stage_q)
                ST_FADDR: stage_q <= ST_FDATA;
                ST_FDATA: begin
                    ir_q    <= mem_rdata;
                    pc_q    <= pc_q + 1'b1;
                    stage_q <= ST_XADDR;
                end
                ST_XADDR: begin
                    case (dec.kind)
                        K_LOAD, K_ADD: stage_q <= ST_XDATA;
                        K_STORE:       stage_q <= ST_FADDR;
                        K_IN: if (io_ack) begin
                            ac_q    <= io_rdata;
                            stage_q <= ST_FADDR;
                        end
                        K_OUT: if (io_ack) stage_q <= ST_FADDR;
                        default:       stage_q <= ST_HALT;
                    endcase
                end
                ST_XDATA: begin
                    if (dec.kind == K_LOAD) begin
                        ac_q <= mem_rdata;
                    end else begin
                        ac_q  <= sum.word;
                        ovf_q <= ovf_q | sum.ovf;
                    end
                    stage_q <= ST_FADDR;
                end
                default: stage_q <= ST_HALT;
            endcase
        end
    end

    assert_store_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    assert_io_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (io_req && !io_ack) |=> io_req && $stable(io_dev) && $stable(io_dir) && $stable(ac));
    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !io_req));
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc)));
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_FDATA) |=> (pc == $past(pc) + 1'b1) && (ir == $past(mem_rdata)));
endmodule

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr, io_dev, pc;
    logic        mem_we, io_req, io_dir, ovf, halted;
    logic [15:0] mem_wdata, io_wdata, ir, ac;
    logic [15:0] mem_rdata = '0;
    logic [15:0] io_rdata = '0;
    logic        io_ack = 1'b0;

    logic [15:0] mem [0:4095];
    logic [15:0] dev_val [0:15];
    int          wr_count = 0;
    int          out_count = 0;
    logic [11:0] out_dev = '0;
    logic [15:0] out_data = '0;
    int          io_delay = 0;
    int          io_cnt = 0;
    int          tests = 0;
    int          fails = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_req(io_req), .io_dir(io_dir), .io_dev(io_dev), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack),
        .pc(pc), .ir(ir), .ac(ac), .ovf(ovf), .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count      <= wr_count + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (rst) begin
            io_ack <= 1'b0;
            io_cnt <= 0;
        end else if (io_req && !io_ack) begin
            if (io_cnt >= io_delay) begin
                io_ack   <= 1'b1;
                io_cnt   <= 0;
                io_rdata <= dev_val[io_dev[3:0]];
                if (io_dir) begin
                    out_dev   <= io_dev;
                    out_data  <= io_wdata;
                    out_count <= out_count + 1;
                end
            end else begin
                io_cnt <= io_cnt + 1;
            end
        end else begin
            io_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) dev_val[i] = '0;
    endtask

    task automatic release_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_halt(input string req);
        for (int i = 0; i < 200 && !halted; i++) step(1);
        chk(req, {31'd0, halted}, 32'd1);
    endtask

    task automatic t_reset();
        start_reset();
        release_reset();
        chk("R1 pc", {20'd0, pc}, 32'h300);
        chk("R1 ir", {16'd0, ir}, 32'h0);
        chk("R1 ac", {16'd0, ac}, 32'h0);
        chk("R1 flags", {28'd0, ovf, halted, mem_we, io_req}, 32'h0);
    endtask

    task automatic t_program();
        start_reset();
        mem[12'h300] = 16'h1940;
        mem[12'h301] = 16'h5941;
        mem[12'h302] = 16'h2941;
        mem[12'h940] = 16'h0003;
        mem[12'h941] = 16'h0002;
        release_reset();
        chk("R2 fetch addr", {20'd0, mem_addr}, 32'h300);
        step(2);
        chk("R2 ir after fetch", {16'd0, ir}, 32'h1940);
        chk("R2 pc after fetch", {20'd0, pc}, 32'h301);
        step(2);
        chk("R3 load ac", {16'd0, ac}, 32'h0003);
        step(2);
        chk("R2 ir second", {16'd0, ir}, 32'h5941);
        chk("R2 pc second", {20'd0, pc}, 32'h302);
        step(2);
        chk("R5 add ac", {16'd0, ac}, 32'h0005);
        step(2);
        chk("R2 ir third", {16'd0, ir}, 32'h2941);
        chk("R4 we/addr", {19'd0, mem_we, mem_addr}, {19'd0, 1'b1, 12'h941});
        chk("R4 wdata", {16'd0, mem_wdata}, 32'h0005);
        step(1);
        chk("R4 strobe drops", {31'd0, mem_we}, 32'd0);
        chk("R11 mem 941", {16'd0, mem[12'h941]}, 32'h0005);
        chk("R11 mem 940", {16'd0, mem[12'h940]}, 32'h0003);
        chk("R11 pc", {20'd0, pc}, 32'h303);
    endtask

    task automatic run_add(input string req, input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] exp, input logic exp_ovf);
        start_reset();
        mem[12'h300] = 16'h1310;
        mem[12'h301] = 16'h5311;
        mem[12'h302] = 16'h2312;
        mem[12'h310] = a;
        mem[12'h311] = b;
        release_reset();
        wait_halt(req);
        chk(req, {16'd0, mem[12'h312]}, {16'd0, exp});
        chk(req, {31'd0, ovf}, {31'd0, exp_ovf});
    endtask

    task automatic t_sticky();
        start_reset();
        mem[12'h300] = 16'h1310;
        mem[12'h301] = 16'h5311;
        mem[12'h302] = 16'h5313;
        mem[12'h303] = 16'h2312;
        mem[12'h310] = 16'h7FFF;
        mem[12'h311] = 16'h0001;
        mem[12'h313] = 16'h0001;
        release_reset();
        wait_halt("R7 sticky run");
        chk("R7 sticky result", {16'd0, mem[12'h312]}, 32'h0001);
        chk("R7 sticky flag", {31'd0, ovf}, 32'd1);
    endtask

    task automatic t_io();
        int oc;
        start_reset();
        mem[12'h300] = 16'h3005;
        mem[12'h301] = 16'h5310;
        mem[12'h302] = 16'h7006;
        mem[12'h310] = 16'h0004;
        dev_val[5]   = 16'h0007;
        io_delay     = 3;
        oc           = out_count;
        release_reset();
        step(2);
        chk("R8 request", {19'd0, io_req, io_dir, mem_we, io_dev}, {19'd0, 1'b1, 1'b0, 1'b0, 12'h005});
        step(2);
        chk("R8 still waiting", {31'd0, io_req}, 32'd1);
        chk("R8 ac held", {16'd0, ac}, 32'h0);
        wait_halt("R9 io run");
        chk("R8 R9 ac", {16'd0, ac}, 32'h000B);
        chk("R9 out dev", {20'd0, out_dev}, 32'h006);
        chk("R9 out data", {16'd0, out_data}, 32'h000B);
        chk("R9 out count", out_count - oc, 32'd1);
        io_delay = 0;
    endtask

    task automatic t_halt();
        int wc;
        logic [11:0] pc_h;
        start_reset();
        mem[12'h300] = 16'h1310;
        mem[12'h301] = 16'hA123;
        mem[12'h302] = 16'h2312;
        mem[12'h310] = 16'h0009;
        mem[12'h312] = 16'h1111;
        release_reset();
        wait_halt("R10 halt");
        pc_h = pc;
        wc   = wr_count;
        chk("R10 pc at halt", {20'd0, pc_h}, 32'h302);
        step(10);
        chk("R10 pc frozen", {20'd0, pc}, 32'h302);
        chk("R10 still halted", {31'd0, halted}, 32'd1);
        chk("R10 no writes", wr_count - wc, 32'd0);
        chk("R10 mem kept", {16'd0, mem[12'h312]}, 32'h1111);
        chk("R10 no io", {31'd0, io_req}, 32'd0);
        chk("R10 ir", {16'd0, ir}, 32'hA123);
    endtask

    initial begin
        t_reset();
        t_program();
        run_add("R5 like positive", 16'h0004, 16'h0003, 16'h0007, 1'b0);
        run_add("R5 like negative", 16'h8004, 16'h8003, 16'h8007, 1'b0);
        run_add("R6 neg larger", 16'h8005, 16'h0003, 16'h8002, 1'b0);
        run_add("R6 pos smaller first", 16'h0003, 16'h8005, 16'h8002, 1'b0);
        run_add("R6 cancel", 16'h0005, 16'h8005, 16'h0000, 1'b0);
        run_add("R6 neg zeros", 16'h8000, 16'h8000, 16'h0000, 1'b0);
        run_add("R7 carry", 16'h7FFF, 16'h0001, 16'h0000, 1'b1);
        t_sticky();
        t_io();
        t_halt();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule